// File: doc/BRIEF.md
# Sparse Boolean Lookup Layer

This block is one hidden layer of a logic-only control policy. It takes a flat vector of input bits and produces a flat vector of output bits, where every output bit is an arbitrary Boolean function of a small fixed number K of input bits. Each output has its own wiring (the K input positions it reads) and its own truth table of 2^K bits. Both are elaboration-time parameters, so the layer is pure lookup logic with no arithmetic, no multipliers and no memory macros.

Layers are cascaded by feeding the output vector and valid flag of one instance into the next. A parameter selects whether the result leaves the layer combinationally in the same cycle or through one register stage. This lets an integrator place pipeline cuts only where timing needs them, so the whole stack stays within a few cycles of latency. Wiring entries that point past the end of the input vector stop elaboration.

Top module: `sparse_logic_layer`

## Requirements
- R1: Output bit j equals bit A of truth table j, where the table is `TABLES[j*2^K +: 2^K]` and A is a K-bit address whose bit s is `in_bits[W]`, with W the index held in `WIRING[(j*K+s)*IDX_W +: IDX_W]`; slot s=0 gives the address LSB.
- R2: Toggling an input bit that is not listed in the wiring of output j leaves output j unchanged.
- R3: The same input index may appear in several slots of one output; every such slot carries that input's value into its address bit.
- R4: With REGISTER_OUT=0, `out_bits` reflects `in_bits` in the same cycle, and `out_valid` equals `in_valid`.
- R5: With REGISTER_OUT=1, a vector presented with `in_valid` high on one rising edge appears on `out_bits` with `out_valid` high after that edge, and `out_valid` is low in every cycle after an edge where `in_valid` was low.
- R6: With REGISTER_OUT=1, `out_bits` keep their last captured value while `in_valid` is low.
- R7: With REGISTER_OUT=1, an active-low `rst_n` forces `out_valid` and `out_bits` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_bits | input | IN_W | Bit vector from the previous layer or encoder |
| out_valid | output | 1 | Output vector is valid |
| out_bits | output | OUT_N | One bit per lookup function |

## Verification
On every cycle the assertions check the register stage against the lookup network that feeds it: a valid input is captured exactly one edge later, the valid flag follows with the same delay, and an idle cycle leaves the outputs stable; in combinational mode they check the pass-through. Whether each table is addressed with the correct slot order, whether repeated wiring indices behave, and whether unwired inputs have no influence can only be shown by the bench's scenarios, which compare every output against functions written directly from the requirements over all input patterns.

// File: rtl/slut_pkg.sv
package slut_pkg;

    // Width of one wiring field; limits a layer to 256 input bits.
    localparam int unsigned SLUT_IDX_W = 8;

    // Number of entries in a truth table for a k-input function.
    function automatic int unsigned tt_bits(input int unsigned k);
        return 32'd1 << k;
    endfunction

    // Index width needed to select one of n bits.
    function automatic int unsigned sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/slut_cell.sv
module slut_cell #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned K     = 3,
    parameter int unsigned IDX_W = slut_pkg::SLUT_IDX_W,
    parameter logic [K*IDX_W-1:0]            WIRES = '0,
    parameter logic [slut_pkg::tt_bits(K)-1:0] TT  = '0
) (
    input  logic [IN_W-1:0] in_bits,
    output logic            y
);
    localparam int unsigned SEL_W = slut_pkg::sel_bits(IN_W);

    logic [K-1:0] addr;

    // Gather the K selected wires; slot 0 is the address LSB.
    always_comb begin
        for (int s = 0; s < int'(K); s++) begin
            addr[s] = in_bits[WIRES[s*IDX_W +: SEL_W]];
        end
    end

    assign y = TT[addr];

endmodule

// File: rtl/slut_pipe.sv
module slut_pipe #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_bits,
    output logic         out_valid,
    output logic [W-1:0] out_bits
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] bits;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.bits = in_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_bits  = stage_q.bits;

endmodule

// File: rtl/sparse_logic_layer.sv
module sparse_logic_layer #(
    parameter int unsigned IN_W         = 8,
    parameter int unsigned OUT_N        = 4,
    parameter int unsigned K            = 3,
    parameter int unsigned IDX_W        = slut_pkg::SLUT_IDX_W,
    parameter bit          REGISTER_OUT = 1'b1,
    parameter logic [OUT_N*K*IDX_W-1:0] WIRING =
        96'h02_00_06_06_04_04_05_03_07_02_01_00,
    parameter logic [OUT_N*slut_pkg::tt_bits(K)-1:0] TABLES =
        32'h01_80_AC_96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_bits,
    output logic             out_valid,
    output logic [OUT_N-1:0] out_bits
);
    localparam int unsigned TT_W    = slut_pkg::tt_bits(K);
    localparam int unsigned FIELD_W = K * IDX_W;

    logic [OUT_N-1:0] cell_bits;

    for (genvar j = 0; j < int'(OUT_N); j++) begin : g_out
        for (genvar s = 0; s < int'(K); s++) begin : g_range
            if (int'(WIRING[(j*K+s)*IDX_W +: IDX_W]) >= int'(IN_W)) begin : g_bad
                $error("wiring index out of range for output %0d slot %0d", j, s);
            end
        end

        slut_cell #(
            .IN_W  (IN_W),
            .K     (K),
            .IDX_W (IDX_W),
            .WIRES (WIRING[j*FIELD_W +: FIELD_W]),
            .TT    (TABLES[j*TT_W +: TT_W])
        ) u_cell (
            .in_bits (in_bits),
            .y       (cell_bits[j])
        );
    end

    if (REGISTER_OUT) begin : g_reg
        slut_pipe #(
            .W (OUT_N)
        ) u_pipe (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .in_bits   (cell_bits),
            .out_valid (out_valid),
            .out_bits  (out_bits)
        );
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_bits  = cell_bits;
    end

endmodule

// File: rtl/slut_checker.sv
module slut_checker #(
    parameter int unsigned OUT_N        = 4,
    parameter bit          REGISTER_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OUT_N-1:0] lut_bits,
    input logic             out_valid,
    input logic [OUT_N-1:0] out_bits
);
    if (REGISTER_OUT) begin : g_reg_chk
        // R5: valid is delayed by exactly one edge
        a_r5_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r5_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R5: the lookup result is captured one edge after a valid input
        a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_bits == $past(lut_bits)));
        // R6: idle cycles do not disturb the held result
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_bits));
    end else begin : g_comb_chk
        // R4: combinational path
        a_r4_pass_bits: assert property (@(posedge clk) disable iff (!rst_n)
            out_bits == lut_bits);
        a_r4_pass_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
    end

endmodule

bind sparse_logic_layer slut_checker #(
    .OUT_N        (OUT_N),
    .REGISTER_OUT (REGISTER_OUT)
) u_slut_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lut_bits  (cell_bits),
    .out_valid (out_valid),
    .out_bits  (out_bits)
);

// File: tb/sparse_logic_layer_bench.sv
module sparse_logic_layer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_bits = '0;
    logic       out_valid, out_valid_c;
    logic [3:0] out_bits, out_bits_c;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    logic [3:0] last_exp = '0;
    logic [3:0] exp_q[$];

    always #10 clk = ~clk;

    sparse_logic_layer u_sparse_logic_layer (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_bits (in_bits),
        .out_valid (out_valid), .out_bits (out_bits)
    );

    sparse_logic_layer #(.REGISTER_OUT (1'b0)) u_sparse_logic_layer_comb (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_bits (in_bits),
        .out_valid (out_valid_c), .out_bits (out_bits_c)
    );

    // Expected functions from the default wiring and tables:
    // out0 = xor of in0,in1,in2; out1 = slot2 (in5) ? slot0 (in7) : slot1 (in3);
    // out2 = in4 AND in6 (in4 wired twice); out3 = NOR of in6,in0,in2.
    function automatic logic [3:0] model(input logic [7:0] i);
        logic [3:0] m;
        m[0] = i[0] ^ i[1] ^ i[2];
        m[1] = i[5] ? i[7] : i[3];
        m[2] = i[4] & i[6];
        m[3] = ~(i[6] | i[0] | i[2]);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [3:0] act,
                         input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present a vector, check the combinational copy, queue the expectation.
    task automatic send(input logic [7:0] v, input bit vld);
        @(negedge clk);
        in_bits  = v;
        in_valid = vld;
        #1;
        check(out_bits_c == model(v), "R1 R4 comb bits", out_bits_c, model(v));
        check(out_valid_c == vld, "R4 comb valid", {3'b0, out_valid_c}, {3'b0, vld});
        if (vld) exp_q.push_back(model(v));
    endtask

    // Monitor: pops expectations as the registered instance produces results.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected valid", out_bits, 4'h0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(out_bits == e, "R1 R5 registered bits", out_bits, e);
                    last_exp  = e;
                    have_last = 1'b1;
                end
            end else begin
                check(exp_q.size() == 0, "R5 result late",
                      4'(exp_q.size()), 4'h0);
                if (have_last)
                    check(out_bits == last_exp, "R6 hold while idle", out_bits, last_exp);
            end
        end
    end

    initial begin
        logic [3:0] a, b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_bits == 4'h0, "R7 reset state",
              {out_valid, out_bits[2:0]}, 4'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: in3 is not wired to outputs 0, 2 and 3
        send(8'h00, 1'b1);
        a = out_bits_c;
        send(8'h08, 1'b1);
        b = out_bits_c;
        check({a[3:2], a[0]} == {b[3:2], b[0]}, "R2 unwired input ignored", b, a);

        // R3: in4 feeds two slots of output 2
        send(8'h10, 1'b1);
        check(out_bits_c[2] == 1'b0, "R3 repeated wire low", out_bits_c, {1'b0, 3'b0});
        send(8'h50, 1'b1);
        check(out_bits_c[2] == 1'b1, "R3 repeated wire high", out_bits_c, 4'h4);

        // R1 slot order: in5=1 selects in7, in5=0 selects in3
        send(8'hA0, 1'b1);
        check(out_bits_c[1] == 1'b1, "R1 slot order select", out_bits_c, 4'h2);
        send(8'h28, 1'b1);
        check(out_bits_c[1] == 1'b0, "R1 slot order other", out_bits_c, 4'h0);

        // Full sweep with idle gaps (R1 R5 R6)
        for (int v = 0; v < 256; v++) begin
            send(8'(v), (v % 5) != 4);
        end
        for (int v = 0; v < 4; v++) begin
            send(8'(v * 37), 1'b0);
        end
        @(negedge clk);
        check(exp_q.size() == 0, "R5 all results seen", 4'(exp_q.size()), 4'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule